// File: doc/BRIEF.md
# SPI Master Burst Engine

This block is a byte-wide SPI master. Software reaches it through a word-addressed register port. It queues outgoing bytes in a transmit FIFO, sets how many bytes the burst clocks in total and how many of them come from that FIFO, and then sets a start bit. The engine shifts the whole burst and collects incoming bytes in a receive FIFO. When the last byte is done it raises a completion flag, which can drive an interrupt. The serial bit rate comes from an external divider, which pulses `half_tick` once per half SCLK period. Chip-select is handled outside this block.

The transfer state machine has five states:

- `S_IDLE` waits for an armed start. A burst count of zero takes it straight to `S_FINISH`; any other count takes it to `S_FETCH`.
- `S_FETCH` loads the next byte into the shifter and moves to `S_LEAD`.
- `S_LEAD` waits for a tick, makes the leading SCLK edge, and moves to `S_TRAIL`.
- `S_TRAIL` waits for a tick and makes the trailing edge. It returns to `S_LEAD` while bits of the byte remain. After the eighth bit it goes to `S_FETCH` while bytes remain, or to `S_FINISH` after the last byte.
- `S_FINISH` lasts one cycle. It clears the start bit, sets the completion flag, and returns to `S_IDLE`.

Registers are addressed as 32-bit words by word index:

| Index | Register |
|---|---|
| 0 | receive data (read pops one byte) |
| 1 | transmit data (write pushes `wdata[7:0]`) |
| 2 | control |
| 3 | interrupt enable |
| 4 | interrupt status |
| 8 | burst count (24 bits) |
| 9 | transmit count (24 bits) |
| 10 | FIFO levels |

Control bits:

| Bit | Function |
|---|---|
| 0 | enable |
| 1 | master |
| 2 | CPHA |
| 3 | CPOL |
| 6 | LSB-first |
| 8 | TX FIFO reset |
| 9 | RX FIFO reset |
| 10 | start |
| 15 | discard received bytes |

Top module: `spi_burst_engine`

## Requirements
- R1: After reset the control, interrupt enable and interrupt status registers and both FIFO levels read zero, SCLK is low and `irq` is low.
- R2: A write to word index 1 pushes one byte into the TX FIFO. A read of word index 0 returns and pops the oldest RX byte. Word index 10 reports the RX level in bits 6:0 and the TX level in bits 22:16.
- R3: In mode 0 (CPOL=0, CPHA=0) each byte goes out MSB first: MOSI is valid before and updated after each falling edge, and MISO is captured on each rising edge.
- R4: SCLK rests at the CPOL level (control bit 3). With CPHA (control bit 2) set, MOSI updates on the leading edge and MISO is captured on the trailing edge.
- R5: With control bit 6 set, bytes are sent and assembled LSB first.
- R6: A burst clocks exactly burst-count bytes (8 edges of each kind per byte). The first transmit-count bytes are popped from the TX FIFO and the rest are sent as 0x00.
- R7: With control bit 15 set, received bytes are not written to the RX FIFO.
- R8: The start bit (control bit 10) reads 1 while the burst runs. It reads 0, and status bit 16 reads 1, from the cycle after the final byte's last edge.
- R9: Status bit 16 is cleared only by writing 1 to it. `irq` is high only while both status bit 16 and enable bit 16 are set.
- R10: Control bits 8 and 9 each empty only their own FIFO and read back as 0 afterwards.
- R11: The start bit has no effect while the enable bit or the master bit is clear: SCLK does not move and no completion is flagged.
- R12: Each FIFO holds 64 bytes. Pushes into a full FIFO are dropped and its level stays at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register word index |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX on index 0) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| half_tick | input | 1 | One-cycle pulse per half SCLK period |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| irq | output | 1 | Completion interrupt |

## Verification
A state machine stuck in `S_LEAD` or `S_TRAIL` shows within one half period: SCLK stops toggling, the start bit stays at 1 and status bit 16 never rises. A bit counter off by one shows up as a wrong number of sampled edges, or as bytes shifted by one bit on MOSI and in the RX FIFO, as soon as the first burst ends. A wrong byte index or transmit-count compare shows at the ports as a non-zero pad byte, or as a TX level left behind after the burst. FIFO pointer faults appear at word index 10 right after pushes, pops or resets.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    // register word indices
    localparam int RIDX_RXD   = 0;
    localparam int RIDX_TXD   = 1;
    localparam int RIDX_CTRL  = 2;
    localparam int RIDX_IEN   = 3;
    localparam int RIDX_ISTA  = 4;
    localparam int RIDX_BURST = 8;
    localparam int RIDX_XMIT  = 9;
    localparam int RIDX_FSTA  = 10;

    // control bit positions
    localparam int CB_EN   = 0;
    localparam int CB_MST  = 1;
    localparam int CB_CPHA = 2;
    localparam int CB_CPOL = 3;
    localparam int CB_LSB  = 4 + 2;
    localparam int CB_TRST = 8;
    localparam int CB_RRST = 9;
    localparam int CB_GO   = 10;
    localparam int CB_DROP = 15;

    localparam int IB_DONE = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LEAD,
        S_TRAIL,
        S_FINISH
    } xfer_state_e;

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction
endpackage

// File: rtl/sbe_byte_fifo.sv
module sbe_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LW-1:0]    level,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [LW-1:0]    cnt;
    logic             full;

    assign full  = (cnt == LW'(DEPTH));
    assign empty = (cnt == '0);
    assign level = cnt;
    assign head  = mem[rp];

    wire do_push = push && !full;
    wire do_pop  = pop && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LW'(DEPTH)); // R12
    AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full); // R12
    AST_FIFO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0)); // R10
endmodule

// File: rtl/sbe_shifter.sv
module sbe_shifter
    import spi_burst_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             lsb_first,
    input  logic             drop_rx,
    input  logic             half_tick,
    input  logic [CNT_W-1:0] burst_cnt,
    input  logic [CNT_W-1:0] xmit_cnt,
    input  logic [7:0]       tx_head,
    input  logic             tx_empty,
    input  logic             miso,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [7:0]       rx_byte,
    output logic             done,
    output logic             sclk,
    output logic             mosi
);
    xfer_state_e      state, state_nx;
    logic [CNT_W-1:0] idx;
    logic [2:0]       bit_cnt;
    logic [7:0]       tx_sr, rx_sr;
    logic             sclk_act;

    logic       from_fifo, last_edge, tick_lead, tick_trail;
    logic [7:0] fetched, rx_next, rx_word;

    assign from_fifo  = (idx < xmit_cnt) && !tx_empty;
    assign fetched    = from_fifo ? tx_head : 8'h00;
    assign rx_next    = {rx_sr[6:0], miso};
    assign tick_lead  = (state == S_LEAD)  && half_tick;
    assign tick_trail = (state == S_TRAIL) && half_tick;
    assign last_edge  = tick_trail && (bit_cnt == 3'd7);
    assign rx_word    = cpha ? rx_next : rx_sr;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (go) state_nx = (burst_cnt == '0) ? S_FINISH : S_FETCH;
            S_FETCH:  state_nx = S_LEAD;
            S_LEAD:   if (half_tick) state_nx = S_TRAIL;
            S_TRAIL:  if (half_tick) begin
                          if (bit_cnt != 3'd7)                    state_nx = S_LEAD;
                          else if (idx == burst_cnt - CNT_W'(1))  state_nx = S_FINISH;
                          else                                    state_nx = S_FETCH;
                      end
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            bit_cnt  <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            sclk_act <= 1'b0;
        end else begin
            if (state == S_IDLE && go) idx <= '0;
            if (state == S_FETCH) begin
                tx_sr   <= lsb_first ? rev8(fetched) : fetched;
                bit_cnt <= '0;
            end
            if (tick_lead) begin
                sclk_act <= 1'b1;
                if (!cpha) rx_sr <= rx_next;
                if (cpha && bit_cnt != 3'd0) tx_sr <= {tx_sr[6:0], 1'b0};
            end
            if (tick_trail) begin
                sclk_act <= 1'b0;
                if (cpha) rx_sr <= rx_next;
                if (!cpha && bit_cnt != 3'd7) tx_sr <= {tx_sr[6:0], 1'b0};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) idx <= idx + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        tx_pop  = (state == S_FETCH) && from_fifo;
        rx_push = last_edge && !drop_rx;
        rx_byte = lsb_first ? rev8(rx_word) : rx_word;
        done    = (state == S_FINISH);
        sclk    = cpol ^ sclk_act;
        mosi    = tx_sr[7];
    end

    AST_IDLE_CLOCK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sclk_act); // R4
    AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH || state == S_LEAD || state == S_TRAIL) |-> (idx < burst_cnt)); // R6
    AST_EDGE_PAIRING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LEAD) |-> !sclk_act); // R3
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 24,
    localparam int LW        = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              half_tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              irq
);
    logic ctrl_en, ctrl_mst, ctrl_cpha, ctrl_cpol, ctrl_lsb;
    logic ctrl_trst, ctrl_rrst, ctrl_go, ctrl_drop;
    logic ien_done, sta_done;
    logic [CNT_W-1:0] burst_q, xmit_q;

    logic          tx_pop, tx_empty, rx_push, rx_empty, shf_done;
    logic [7:0]    tx_head, rx_head, rx_byte;
    logic [LW-1:0] tx_lvl, rx_lvl;

    wire unused_wdata_hi = ^bus_wdata[31:CNT_W];

    wire sel_rxd   = (bus_addr == ADDR_W'(RIDX_RXD));
    wire sel_txd   = (bus_addr == ADDR_W'(RIDX_TXD));
    wire sel_ctrl  = (bus_addr == ADDR_W'(RIDX_CTRL));
    wire sel_ien   = (bus_addr == ADDR_W'(RIDX_IEN));
    wire sel_ista  = (bus_addr == ADDR_W'(RIDX_ISTA));
    wire sel_burst = (bus_addr == ADDR_W'(RIDX_BURST));
    wire sel_xmit  = (bus_addr == ADDR_W'(RIDX_XMIT));
    wire sel_fsta  = (bus_addr == ADDR_W'(RIDX_FSTA));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_mst  <= 1'b0;
            ctrl_cpha <= 1'b0;
            ctrl_cpol <= 1'b0;
            ctrl_lsb  <= 1'b0;
            ctrl_trst <= 1'b0;
            ctrl_rrst <= 1'b0;
            ctrl_go   <= 1'b0;
            ctrl_drop <= 1'b0;
            ien_done  <= 1'b0;
            sta_done  <= 1'b0;
            burst_q   <= '0;
            xmit_q    <= '0;
        end else begin
            ctrl_trst <= 1'b0;
            ctrl_rrst <= 1'b0;
            if (bus_wr && sel_ctrl) begin
                ctrl_en   <= bus_wdata[CB_EN];
                ctrl_mst  <= bus_wdata[CB_MST];
                ctrl_cpha <= bus_wdata[CB_CPHA];
                ctrl_cpol <= bus_wdata[CB_CPOL];
                ctrl_lsb  <= bus_wdata[CB_LSB];
                ctrl_trst <= bus_wdata[CB_TRST];
                ctrl_rrst <= bus_wdata[CB_RRST];
                ctrl_go   <= bus_wdata[CB_GO];
                ctrl_drop <= bus_wdata[CB_DROP];
            end
            if (shf_done) ctrl_go <= 1'b0;
            if (bus_wr && sel_ien) ien_done <= bus_wdata[IB_DONE];
            if (bus_wr && sel_ista && bus_wdata[IB_DONE]) sta_done <= 1'b0;
            if (shf_done) sta_done <= 1'b1;
            if (bus_wr && sel_burst) burst_q <= bus_wdata[CNT_W-1:0];
            if (bus_wr && sel_xmit)  xmit_q  <= bus_wdata[CNT_W-1:0];
        end
    end

    assign irq = sta_done && ien_done;

    sbe_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(ctrl_trst),
        .push(bus_wr && sel_txd), .din(bus_wdata[7:0]),
        .pop(tx_pop), .head(tx_head), .level(tx_lvl), .empty(tx_empty)
    );

    sbe_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(ctrl_rrst),
        .push(rx_push), .din(rx_byte),
        .pop(bus_rd && sel_rxd), .head(rx_head), .level(rx_lvl), .empty(rx_empty)
    );

    sbe_shifter #(.CNT_W(CNT_W)) i_shifter (
        .clk(clk), .rst_n(rst_n),
        .go(ctrl_go && ctrl_en && ctrl_mst),
        .cpol(ctrl_cpol), .cpha(ctrl_cpha), .lsb_first(ctrl_lsb), .drop_rx(ctrl_drop),
        .half_tick(half_tick), .burst_cnt(burst_q), .xmit_cnt(xmit_q),
        .tx_head(tx_head), .tx_empty(tx_empty), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte), .done(shf_done),
        .sclk(sclk), .mosi(mosi)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_rxd) begin
            bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
        end else if (sel_ctrl) begin
            bus_rdata[CB_EN]   = ctrl_en;
            bus_rdata[CB_MST]  = ctrl_mst;
            bus_rdata[CB_CPHA] = ctrl_cpha;
            bus_rdata[CB_CPOL] = ctrl_cpol;
            bus_rdata[CB_LSB]  = ctrl_lsb;
            bus_rdata[CB_TRST] = ctrl_trst;
            bus_rdata[CB_RRST] = ctrl_rrst;
            bus_rdata[CB_GO]   = ctrl_go;
            bus_rdata[CB_DROP] = ctrl_drop;
        end else if (sel_ien) begin
            bus_rdata[IB_DONE] = ien_done;
        end else if (sel_ista) begin
            bus_rdata[IB_DONE] = sta_done;
        end else if (sel_burst) begin
            bus_rdata = 32'(burst_q);
        end else if (sel_xmit) begin
            bus_rdata = 32'(xmit_q);
        end else if (sel_fsta) begin
            bus_rdata = (32'(tx_lvl) << 16) | 32'(rx_lvl);
        end
    end

    AST_GO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        shf_done |=> !ctrl_go); // R8
    AST_DONE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        shf_done |=> sta_done); // R8
    AST_DROP_KEEPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_drop && !(bus_rd && sel_rxd) && !ctrl_rrst) |=> (rx_lvl == $past(rx_lvl))); // R7
endmodule

// File: tb/test_spi_burst_engine.sv
module test_spi_burst_engine;
    import spi_burst_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        half_tick = 1'b0;
    logic        miso, sclk, mosi, irq;

    int checks = 0, errors = 0;
    logic [127:0] slv_sr = '0, cap = '0;
    int  cap_n = 0, sclk_edges = 0;
    bit  busy_tb = 0, cpol_tb = 0, cpha_tb = 0;
    logic [7:0] tx_bytes [8];
    logic [7:0] slv_bytes [8];
    int  ntx = 0;

    always #10 clk = ~clk;

    int tick_div = 0;
    always @(posedge clk) begin
        tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
        half_tick <= (tick_div == 3);
    end

    spi_burst_engine i_spi_burst_engine (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .half_tick(half_tick),
        .miso(miso), .sclk(sclk), .mosi(mosi), .irq(irq)
    );

    // slave model
    assign miso = slv_sr[127];
    always @(posedge sclk or negedge sclk) begin
        sclk_edges++;
        if (busy_tb) begin
            if ((sclk != cpol_tb) ^ cpha_tb) begin
                cap = {cap[126:0], mosi};
                cap_n++;
            end else begin
                slv_sr = {slv_sr[126:0], 1'b0};
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 4'(idx); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int idx, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 4'(idx); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] mode_word(bit cpol, bit cpha, bit lsb, bit drop);
        return 32'h3 | (32'(cpha) << CB_CPHA) | (32'(cpol) << CB_CPOL)
             | (32'(lsb) << CB_LSB) | (32'(drop) << CB_DROP);
    endfunction

    task automatic start_burst(input bit cpol, input bit cpha, input bit lsb, input bit drop,
                               input int burst, input int xmit);
        logic [127:0] pat = '0;
        bus_write(RIDX_ISTA, 32'h1_0000);
        bus_write(RIDX_CTRL, mode_word(cpol, cpha, lsb, drop) | 32'h300);
        repeat (3) @(negedge clk);
        for (int i = 0; i < ntx; i++) bus_write(RIDX_TXD, 32'(tx_bytes[i]));
        for (int i = 0; i < 8; i++) pat[127-8*i -: 8] = lsb ? rev8(slv_bytes[i]) : slv_bytes[i];
        slv_sr = cpha ? {1'b0, pat[127:1]} : pat;
        cap = '0; cap_n = 0;
        cpol_tb = cpol; cpha_tb = cpha; busy_tb = 1;
        bus_write(RIDX_BURST, 32'(burst));
        bus_write(RIDX_XMIT, 32'(xmit));
        bus_write(RIDX_CTRL, mode_word(cpol, cpha, lsb, drop) | 32'h400);
    endtask

    task automatic wait_done(input string req);
        logic [31:0] d;
        bit ok = 0;
        for (int n = 0; n < 3000 && !ok; n++) begin
            bus_read(RIDX_ISTA, d);
            ok = d[IB_DONE];
        end
        busy_tb = 0;
        chk(req, 32'(ok), 32'd1);
    endtask

    task automatic check_mosi(input string req, input int burst, input int xmit, input bit lsb);
        logic [7:0] e;
        chk(req, 32'(cap_n), 32'(8 * burst));
        for (int i = 0; i < burst; i++) begin
            e = (i < xmit && i < ntx) ? tx_bytes[i] : 8'h00;
            if (lsb) e = rev8(e);
            chk(req, 32'(cap[8*(burst-1-i) +: 8]), 32'(e));
        end
    endtask

    task automatic check_rx(input string req, input int burst);
        logic [31:0] d;
        bus_read(RIDX_FSTA, d);
        chk(req, d & 32'h7F, 32'(burst));
        for (int i = 0; i < burst; i++) begin
            bus_read(RIDX_RXD, d);
            chk(req, d, 32'(slv_bytes[i]));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(RIDX_CTRL, d); chk("R1", d, 32'd0);
        bus_read(RIDX_IEN, d);  chk("R1", d, 32'd0);
        bus_read(RIDX_ISTA, d); chk("R1", d, 32'd0);
        bus_read(RIDX_FSTA, d); chk("R1", d, 32'd0);
        chk("R1", {30'd0, sclk, irq}, 32'd0);
    endtask

    task automatic t_mode0();
        logic [31:0] d;
        tx_bytes[0] = 8'hA5; tx_bytes[1] = 8'h3C; ntx = 2;
        slv_bytes[0] = 8'hC3; slv_bytes[1] = 8'h96;
        bus_write(RIDX_ISTA, 32'h1_0000);
        bus_write(RIDX_CTRL, 32'h303);
        repeat (3) @(negedge clk);
        bus_write(RIDX_TXD, 32'h11);
        bus_read(RIDX_FSTA, d); chk("R2", d, 32'h0001_0000);
        start_burst(0, 0, 0, 0, 2, 2);
        wait_done("R3");
        check_mosi("R3", 2, 2, 0);
        bus_read(RIDX_FSTA, d); chk("R2", d, 32'h0000_0002);
        check_rx("R3", 2);
    endtask

    task automatic t_modes();
        logic [31:0] d;
        for (int m = 1; m < 4; m++) begin
            tx_bytes[0] = 8'h5A ^ 8'(m); ntx = 1;
            slv_bytes[0] = 8'hE1 ^ 8'(m << 4);
            bus_write(RIDX_CTRL, mode_word(m[1], m[0], 0, 0));
            repeat (3) @(negedge clk);
            chk("R4", 32'(sclk), 32'(m[1]));
            start_burst(m[1], m[0], 0, 0, 1, 1);
            wait_done("R4");
            check_mosi("R4", 1, 1, 0);
            check_rx("R4", 1);
            chk("R4", 32'(sclk), 32'(m[1]));
        end
        bus_write(RIDX_CTRL, 32'h3);
        bus_read(RIDX_FSTA, d);
    endtask

    task automatic t_lsb();
        tx_bytes[0] = 8'h01; tx_bytes[1] = 8'hB4; ntx = 2;
        slv_bytes[0] = 8'h80; slv_bytes[1] = 8'h2D;
        start_burst(0, 0, 1, 0, 2, 2);
        wait_done("R5");
        check_mosi("R5", 2, 2, 1);
        check_rx("R5", 2);
    endtask

    task automatic t_counts();
        logic [31:0] d;
        tx_bytes[0] = 8'h7E; tx_bytes[1] = 8'h99; ntx = 2;
        for (int i = 0; i < 4; i++) slv_bytes[i] = 8'h10 + 8'(i);
        start_burst(0, 1, 0, 0, 4, 1);
        wait_done("R6");
        check_mosi("R6", 4, 1, 0);
        bus_read(RIDX_FSTA, d); chk("R6", d >> 16, 32'd1);
        check_rx("R6", 4);
    endtask

    task automatic t_drop();
        logic [31:0] d;
        tx_bytes[0] = 8'h21; tx_bytes[1] = 8'h43; tx_bytes[2] = 8'h65; ntx = 3;
        slv_bytes[0] = 8'hFF; slv_bytes[1] = 8'hEE; slv_bytes[2] = 8'hDD;
        start_burst(0, 0, 0, 1, 3, 3);
        wait_done("R7");
        check_mosi("R7", 3, 3, 0);
        bus_read(RIDX_FSTA, d); chk("R7", d, 32'd0);
    endtask

    task automatic t_done_irq();
        logic [31:0] d;
        bus_write(RIDX_IEN, 32'd0);
        tx_bytes[0] = 8'h0F; tx_bytes[1] = 8'hF0; ntx = 2;
        slv_bytes[0] = 8'h33; slv_bytes[1] = 8'h44;
        start_burst(0, 0, 0, 0, 2, 2);
        bus_read(RIDX_CTRL, d); chk("R8", (d >> CB_GO) & 1, 32'd1);
        bus_read(RIDX_ISTA, d); chk("R8", d, 32'd0);
        wait_done("R8");
        bus_read(RIDX_CTRL, d); chk("R8", (d >> CB_GO) & 1, 32'd0);
        chk("R9", 32'(irq), 32'd0);
        bus_write(RIDX_IEN, 32'h1_0000);
        @(negedge clk); chk("R9", 32'(irq), 32'd1);
        bus_write(RIDX_ISTA, 32'h0000_FFFF);
        bus_read(RIDX_ISTA, d); chk("R9", d, 32'h1_0000);
        bus_write(RIDX_ISTA, 32'h1_0000);
        bus_read(RIDX_ISTA, d); chk("R9", d, 32'd0);
        chk("R9", 32'(irq), 32'd0);
        check_rx("R8", 2);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        tx_bytes[0] = 8'h01; tx_bytes[1] = 8'h02; tx_bytes[2] = 8'h03; ntx = 3;
        slv_bytes[0] = 8'h5C; slv_bytes[1] = 8'hC5;
        start_burst(0, 0, 0, 0, 2, 0);
        wait_done("R10");
        check_mosi("R10", 2, 0, 0);
        bus_read(RIDX_FSTA, d); chk("R10", d, 32'h0003_0002);
        bus_write(RIDX_CTRL, 32'h203);
        repeat (2) @(negedge clk);
        bus_read(RIDX_FSTA, d); chk("R10", d, 32'h0003_0000);
        bus_read(RIDX_CTRL, d); chk("R10", d, 32'h3);
        bus_write(RIDX_CTRL, 32'h103);
        repeat (2) @(negedge clk);
        bus_read(RIDX_FSTA, d); chk("R10", d, 32'h0);
        bus_read(RIDX_CTRL, d); chk("R10", d, 32'h3);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        int e0;
        bus_write(RIDX_ISTA, 32'h1_0000);
        bus_write(RIDX_BURST, 32'd2);
        e0 = sclk_edges;
        bus_write(RIDX_CTRL, 32'h402);
        repeat (200) @(negedge clk);
        bus_read(RIDX_ISTA, d); chk("R11", d, 32'd0);
        bus_write(RIDX_CTRL, 32'h401);
        repeat (200) @(negedge clk);
        bus_read(RIDX_ISTA, d); chk("R11", d, 32'd0);
        chk("R11", 32'(sclk_edges - e0), 32'd0);
        bus_write(RIDX_CTRL, 32'h3);
    endtask

    task automatic t_depth();
        logic [31:0] d;
        bus_write(RIDX_CTRL, 32'h303);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 70; i++) bus_write(RIDX_TXD, 32'(i));
        bus_read(RIDX_FSTA, d); chk("R12", d, 32'h0040_0000);
        bus_write(RIDX_CTRL, 32'h103);
        repeat (2) @(negedge clk);
        bus_read(RIDX_FSTA, d); chk("R12", d, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_mode0();
        t_modes();
        t_lsb();
        t_counts();
        t_drop();
        t_done_irq();
        t_flush();
        t_gate();
        t_depth();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule